// File: doc/BRIEF.md
# Tagged Two-Size Data Translation Buffer

This block is a first-level data address translation buffer. It keeps two set-associative banks side by side, one for 4 KB pages and one for 2 MB pages, and searches both for every lookup. Each entry carries a virtual machine identifier and an address space identifier next to its virtual page tag. Translations from several guests and processes therefore live together, and a context switch needs no flush. Both hardware threads share all entries freely.

A lookup presents a 48-bit virtual address with its two identifiers. One clock later the registered result gives hit, a 40-bit physical address, the page size and a stored permission field. A page walker installs translations through the fill port. Invalidate commands remove every entry, the entries of one virtual machine, or the entries of one virtual machine and address space pair.

Top module: `vmtlb_top`

## Requirements
- R1: After reset every entry is invalid and `rs_valid` and `rs_hit` are 0. A lookup made before any fill misses.
- R2: A lookup registers its result at the next rising edge. `rs_valid` is high exactly in the cycle after `lk_valid`, and the result fields hold their value while no lookup is made. An entry hits only when it is valid and its virtual page tag, VMID and ASID all equal those of the lookup.
- R3: The small bank takes its set index from VA[15:12] and gives PA = {frame, VA[11:0]} with `rs_large`=0. The large bank takes its set index from VA[23:21] and gives PA = {frame, VA[20:0]} with `rs_large`=1.
- R4: When both banks hit, the result comes from the large bank.
- R5: On a miss, `rs_hit`, `rs_large`, `rs_pa` and `rs_perm` are all 0.
- R6: A fill chooses its way from the contents and replacement state as they stand before that cycle's updates. A valid entry with the same tag, VMID and ASID is rewritten in place. Otherwise the lowest-numbered invalid way is used, and otherwise the way named by the replacement tree.
- R7: Each set keeps a 3-bit replacement tree (node 0 root, node 1 over ways 0-1, node 2 over ways 2-3). A node value of 0 steers the victim to its lower half. A hit and then a fill in the same cycle each set the nodes on their way's path to point away from that way.
- R8: `inv_kind` 0 invalidates every entry in both banks.
- R9: `inv_kind` 1 invalidates every entry whose VMID equals `inv_vmid`, whatever its ASID.
- R10: `inv_kind` 2 invalidates the entries whose VMID and ASID both match `inv_vmid` and `inv_asid`.
- R11: `inv_kind` 3 leaves every entry unchanged.
- R12: A lookup in the same cycle as a fill or invalidate sees the contents from before that cycle, and the next lookup sees the update. When a fill and an invalidate come together, the filled entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_vmid | input | VMID_W | Lookup virtual machine ID |
| lk_asid | input | ASID_W | Lookup address space ID |
| fl_valid | input | 1 | Fill request |
| fl_large | input | 1 | Fill targets the 2 MB bank |
| fl_va | input | VA_W | Virtual address of the filled page |
| fl_pa | input | PA_W | Physical base of the filled page |
| fl_vmid | input | VMID_W | Fill virtual machine ID |
| fl_asid | input | ASID_W | Fill address space ID |
| fl_perm | input | PERM_W | Permission field to store |
| inv_valid | input | 1 | Invalidate request |
| inv_kind | input | 2 | 0 all, 1 by VMID, 2 by VMID and ASID, 3 none |
| inv_vmid | input | VMID_W | VMID to invalidate |
| inv_asid | input | ASID_W | ASID to invalidate |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation found |
| rs_large | output | 1 | Hit came from the 2 MB bank |
| rs_pa | output | PA_W | Translated physical address |
| rs_perm | output | PERM_W | Stored permission field |

## Verification
The bench keeps the bank geometry at its defaults (16 and 8 sets, 4 ways) and narrows VMID to 3 bits and ASID to 4 bits. It draws addresses from a handful of tags over two sets per bank. This makes identifier aliasing, same-set conflicts, full sets with tree-driven eviction and small/large overlap occur often. Directed steps cover in-place refill, a known eviction order, each invalidate kind and the same-cycle orderings.

// File: rtl/vmtlb_pkg.sv
package vmtlb_pkg;
  localparam int SMALL_PAGE_OFF = 12;
  localparam int LARGE_PAGE_OFF = 21;

  typedef enum logic [1:0] {
    INV_ALL   = 2'd0,
    INV_VM    = 2'd1,
    INV_VM_AS = 2'd2,
    INV_NONE  = 2'd3
  } inv_kind_e;
endpackage

// File: rtl/vmtlb_plru.sv
module vmtlb_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_d [SETS];

  function automatic logic [NODES-1:0] point_away(logic [NODES-1:0] t,
                                                  logic [WAY_W-1:0] w);
    int n;
    n = 0;
    for (int l = 0; l < WAY_W; l++) begin
      t[n] = ~w[WAY_W-1-l];
      n = 2 * n + 1 + int'(w[WAY_W-1-l]);
    end
    return t;
  endfunction

  function automatic logic [WAY_W-1:0] follow(logic [NODES-1:0] t);
    int n;
    logic [WAY_W-1:0] w;
    n = 0;
    w = '0;
    for (int l = 0; l < WAY_W; l++) begin
      w = (w << 1) | WAY_W'(t[n]);
      n = 2 * n + 1 + int'(t[n]);
    end
    return w;
  endfunction

  assign vic_way = follow(tree_q[vic_set]);

  always_comb begin
    tree_d = tree_q;
    if (hit_en)  tree_d[hit_set]  = point_away(tree_d[hit_set], hit_way);
    if (fill_en) tree_d[fill_set] = point_away(tree_d[fill_set], fill_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      tree_q <= tree_d;
    end
  end
endmodule

// File: rtl/vmtlb_bank.sv
module vmtlb_bank
  import vmtlb_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int OFF_W  = 12,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int VMID_W = 8,
  parameter int ASID_W = 12,
  parameter int PERM_W = 3,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = VA_W - OFF_W - SET_W,
  localparam int PFN_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic [PERM_W-1:0] hit_perm,
  input  logic              fl_en,
  input  logic [VA_W-1:0]   fl_va,
  input  logic [PFN_W-1:0]  fl_pfn,
  input  logic [VMID_W-1:0] fl_vmid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic              inv_en,
  input  logic [1:0]        inv_kind,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [ASID_W-1:0] inv_asid
);
  logic [WAYS-1:0]   val_q [SETS];
  logic [WAYS-1:0]   val_d [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [VMID_W-1:0] vm_q  [SETS][WAYS];
  logic [ASID_W-1:0] as_q  [SETS][WAYS];
  logic [PFN_W-1:0]  pfn_q [SETS][WAYS];
  logic [PERM_W-1:0] perm_q[SETS][WAYS];

  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0]  lk_match, fl_same;
  logic [WAY_W-1:0] hit_way, fl_way, vic_way;

  function automatic logic [WAY_W-1:0] lowest(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  assign lk_set = lk_va[OFF_W +: SET_W];
  assign lk_tag = lk_va[OFF_W+SET_W +: TAG_W];
  assign fl_set = fl_va[OFF_W +: SET_W];
  assign fl_tag = fl_va[OFF_W+SET_W +: TAG_W];

  // tag compare for the lookup and for the fill (in-place refill detection)
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = val_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag) &&
                    (vm_q[lk_set][w] == lk_vmid) && (as_q[lk_set][w] == lk_asid);
      fl_same[w]  = val_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag) &&
                    (vm_q[fl_set][w] == fl_vmid) && (as_q[fl_set][w] == fl_asid);
    end
  end

  assign hit      = lk_en && (|lk_match);
  assign hit_way  = lowest(lk_match);
  assign hit_pfn  = hit ? pfn_q[lk_set][hit_way]  : '0;
  assign hit_perm = hit ? perm_q[lk_set][hit_way] : '0;

  always_comb begin
    if (|fl_same)               fl_way = lowest(fl_same);
    else if (~&val_q[fl_set])   fl_way = lowest(~val_q[fl_set]);
    else                        fl_way = vic_way;
  end

  vmtlb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_en   (hit),
    .hit_set  (lk_set),
    .hit_way  (hit_way),
    .fill_en  (fl_en),
    .fill_set (fl_set),
    .fill_way (fl_way),
    .vic_set  (fl_set),
    .vic_way  (vic_way)
  );

  // valid next state: invalidate first, then the fill sets its entry
  always_comb begin
    val_d = val_q;
    if (inv_en) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          case (inv_kind_e'(inv_kind))
            INV_ALL:   val_d[s][w] = 1'b0;
            INV_VM:    if (vm_q[s][w] == inv_vmid) val_d[s][w] = 1'b0;
            INV_VM_AS: if ((vm_q[s][w] == inv_vmid) && (as_q[s][w] == inv_asid))
                         val_d[s][w] = 1'b0;
            default:   ;
          endcase
        end
      end
    end
    if (fl_en) val_d[fl_set][fl_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_en) begin
      tag_q [fl_set][fl_way] <= fl_tag;
      vm_q  [fl_set][fl_way] <= fl_vmid;
      as_q  [fl_set][fl_way] <= fl_asid;
      pfn_q [fl_set][fl_way] <= fl_pfn;
      perm_q[fl_set][fl_way] <= fl_perm;
    end
  end
endmodule

// File: rtl/vmtlb_top.sv
module vmtlb_top
  import vmtlb_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 40,
  parameter int SMALL_SETS = 16,
  parameter int LARGE_SETS = 8,
  parameter int WAYS       = 4,
  parameter int VMID_W     = 8,
  parameter int ASID_W     = 12,
  parameter int PERM_W     = 3,
  localparam int SMALL_OFF = SMALL_PAGE_OFF,
  localparam int LARGE_OFF = LARGE_PAGE_OFF,
  localparam int SPFN_W    = PA_W - SMALL_OFF,
  localparam int LPFN_W    = PA_W - LARGE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              fl_valid,
  input  logic              fl_large,
  input  logic [VA_W-1:0]   fl_va,
  input  logic [PA_W-1:0]   fl_pa,
  input  logic [VMID_W-1:0] fl_vmid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_kind,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_large,
  output logic [PA_W-1:0]   rs_pa,
  output logic [PERM_W-1:0] rs_perm
);
  logic [1:0] rsync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  logic              s_hit, l_hit;
  logic [SPFN_W-1:0] s_pfn;
  logic [LPFN_W-1:0] l_pfn;
  logic [PERM_W-1:0] s_perm, l_perm;

  vmtlb_bank #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(SMALL_OFF), .SETS(SMALL_SETS), .WAYS(WAYS),
    .VMID_W(VMID_W), .ASID_W(ASID_W), .PERM_W(PERM_W)
  ) u_small (
    .clk(clk), .rst_n(rst_ok),
    .lk_en(lk_valid), .lk_va(lk_va), .lk_vmid(lk_vmid), .lk_asid(lk_asid),
    .hit(s_hit), .hit_pfn(s_pfn), .hit_perm(s_perm),
    .fl_en(fl_valid && !fl_large), .fl_va(fl_va), .fl_pfn(fl_pa[PA_W-1:SMALL_OFF]),
    .fl_vmid(fl_vmid), .fl_asid(fl_asid), .fl_perm(fl_perm),
    .inv_en(inv_valid), .inv_kind(inv_kind), .inv_vmid(inv_vmid), .inv_asid(inv_asid)
  );

  vmtlb_bank #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(LARGE_OFF), .SETS(LARGE_SETS), .WAYS(WAYS),
    .VMID_W(VMID_W), .ASID_W(ASID_W), .PERM_W(PERM_W)
  ) u_large (
    .clk(clk), .rst_n(rst_ok),
    .lk_en(lk_valid), .lk_va(lk_va), .lk_vmid(lk_vmid), .lk_asid(lk_asid),
    .hit(l_hit), .hit_pfn(l_pfn), .hit_perm(l_perm),
    .fl_en(fl_valid && fl_large), .fl_va(fl_va), .fl_pfn(fl_pa[PA_W-1:LARGE_OFF]),
    .fl_vmid(fl_vmid), .fl_asid(fl_asid), .fl_perm(fl_perm),
    .inv_en(inv_valid), .inv_kind(inv_kind), .inv_vmid(inv_vmid), .inv_asid(inv_asid)
  );

  logic              hit_d, large_d;
  logic [PA_W-1:0]   pa_d;
  logic [PERM_W-1:0] perm_d;

  always_comb begin
    hit_d   = 1'b0;
    large_d = 1'b0;
    pa_d    = '0;
    perm_d  = '0;
    if (l_hit) begin
      hit_d   = 1'b1;
      large_d = 1'b1;
      pa_d    = {l_pfn, lk_va[LARGE_OFF-1:0]};
      perm_d  = l_perm;
    end else if (s_hit) begin
      hit_d   = 1'b1;
      pa_d    = {s_pfn, lk_va[SMALL_OFF-1:0]};
      perm_d  = s_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_large <= 1'b0;
      rs_pa    <= '0;
      rs_perm  <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_hit   <= hit_d;
        rs_large <= large_d;
        rs_pa    <= pa_d;
        rs_perm  <= perm_d;
      end
    end
  end
endmodule

// File: rtl/vmtlb_chk.sv
module vmtlb_chk #(
  parameter int VA_W      = 48,
  parameter int PA_W      = 40,
  parameter int PERM_W    = 3,
  parameter int SMALL_OFF = 12,
  parameter int LARGE_OFF = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_va,
  input logic              fl_valid,
  input logic              inv_valid,
  input logic [1:0]        inv_kind,
  input logic              rs_valid,
  input logic              rs_hit,
  input logic              rs_large,
  input logic [PA_W-1:0]   rs_pa,
  input logic [PERM_W-1:0] rs_perm
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (!rs_valid && !rs_hit));

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lk_valid) |=> rs_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !lk_valid) |=> (!rs_valid && $stable(rs_hit) && $stable(rs_pa)));

  assert_small_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lk_valid) |=> (!rs_hit || rs_pa[SMALL_OFF-1:0] == $past(lk_va[SMALL_OFF-1:0])));

  assert_large_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lk_valid) |=> (!rs_large || (rs_hit && rs_pa[LARGE_OFF-1:0] == $past(lk_va[LARGE_OFF-1:0]))));

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_pa == '0 && !rs_large && rs_perm == '0));

  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && inv_valid && inv_kind == 2'd0 && !fl_valid) ##1 lk_valid |=> !rs_hit);
endmodule

bind vmtlb_top vmtlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PERM_W(PERM_W),
  .SMALL_OFF(SMALL_OFF), .LARGE_OFF(LARGE_OFF)
) u_vmtlb_chk (
  .clk(clk), .rst_n(rst_ok), .lk_valid(lk_valid), .lk_va(lk_va),
  .fl_valid(fl_valid), .inv_valid(inv_valid), .inv_kind(inv_kind),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_large(rs_large),
  .rs_pa(rs_pa), .rs_perm(rs_perm)
);

// File: tb/test_vmtlb_top.sv
module test_vmtlb_top;
  localparam int VM = 3;
  localparam int AS = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid, fl_valid, fl_large, inv_valid;
  logic [47:0]   lk_va, fl_va;
  logic [39:0]   fl_pa;
  logic [VM-1:0] lk_vmid, fl_vmid, inv_vmid;
  logic [AS-1:0] lk_asid, fl_asid, inv_asid;
  logic [2:0]    fl_perm;
  logic [1:0]    inv_kind;
  logic          rs_valid, rs_hit, rs_large;
  logic [39:0]   rs_pa;
  logic [2:0]    rs_perm;

  always #2ns clk = ~clk;

  vmtlb_top #(.VMID_W(VM), .ASID_W(AS)) i_vmtlb_top (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_vmid(lk_vmid), .lk_asid(lk_asid),
    .fl_valid(fl_valid), .fl_large(fl_large), .fl_va(fl_va), .fl_pa(fl_pa),
    .fl_vmid(fl_vmid), .fl_asid(fl_asid), .fl_perm(fl_perm),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_vmid(inv_vmid), .inv_asid(inv_asid),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_large(rs_large), .rs_pa(rs_pa), .rs_perm(rs_perm)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model, index 0 = 4 KB bank, 1 = 2 MB bank
  logic          mv  [2][16][4];
  logic [31:0]   mt  [2][16][4];
  logic [VM-1:0] mvm [2][16][4];
  logic [AS-1:0] mas [2][16][4];
  logic [27:0]   mpf [2][16][4];
  logic [2:0]    mpe [2][16][4];
  logic [2:0]    mpl [2][16];

  logic          e_hit, e_large;
  logic [39:0]   e_pa;
  logic [2:0]    e_perm;

  function automatic int sidx(int z, logic [47:0] va);
    return (z == 1) ? int'(va[23:21]) : int'(va[15:12]);
  endfunction

  function automatic logic [31:0] tg(int z, logic [47:0] va);
    return (z == 1) ? {8'h0, va[47:24]} : va[47:16];
  endfunction

  function automatic logic [2:0] touch(logic [2:0] b, int w);
    b[0] = (w < 2);
    if (w < 2) b[1] = (w == 0);
    else       b[2] = (w == 2);
    return b;
  endfunction

  function automatic int victim(logic [2:0] b);
    if (b[0] == 1'b0) return b[1] ? 1 : 0;
    return b[2] ? 3 : 2;
  endfunction

  task automatic chk(string req, string what, logic [39:0] got, logic [39:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int z = 0; z < 2; z++)
      for (int s = 0; s < 16; s++) begin
        mpl[z][s] = '0;
        for (int w = 0; w < 4; w++) mv[z][s][w] = 1'b0;
      end
  endtask

  // one cycle: drive at negedge, update model, check registered result at next negedge
  task automatic step(string req,
                      bit lk, logic [47:0] lva, logic [VM-1:0] lvm, logic [AS-1:0] las,
                      bit fl, bit flg, logic [47:0] fva, logic [39:0] fpa,
                      logic [VM-1:0] fvm, logic [AS-1:0] fas, logic [2:0] fpe,
                      bit inv, logic [1:0] ik, logic [VM-1:0] ivm, logic [AS-1:0] ias);
    int hw [2];
    bit hh [2];
    int fz, fs, fw;
    lk_valid = lk; lk_va = lva; lk_vmid = lvm; lk_asid = las;
    fl_valid = fl; fl_large = flg; fl_va = fva; fl_pa = fpa;
    fl_vmid = fvm; fl_asid = fas; fl_perm = fpe;
    inv_valid = inv; inv_kind = ik; inv_vmid = ivm; inv_asid = ias;
    e_hit = 1'b0; e_large = 1'b0; e_pa = '0; e_perm = '0;
    for (int z = 0; z < 2; z++) begin
      int s;
      s = sidx(z, lva);
      hh[z] = 1'b0; hw[z] = 0;
      for (int w = 0; w < 4; w++)
        if (!hh[z] && mv[z][s][w] && mt[z][s][w] == tg(z, lva) &&
            mvm[z][s][w] == lvm && mas[z][s][w] == las) begin
          hh[z] = 1'b1; hw[z] = w;
        end
    end
    if (lk && hh[1]) begin
      e_hit = 1'b1; e_large = 1'b1;
      e_pa = {mpf[1][sidx(1, lva)][hw[1]][18:0], lva[20:0]};
      e_perm = mpe[1][sidx(1, lva)][hw[1]];
    end else if (lk && hh[0]) begin
      e_hit = 1'b1;
      e_pa = {mpf[0][sidx(0, lva)][hw[0]], lva[11:0]};
      e_perm = mpe[0][sidx(0, lva)][hw[0]];
    end
    fz = flg ? 1 : 0;
    fs = sidx(fz, fva);
    fw = -1;
    for (int w = 0; w < 4; w++)
      if (fw < 0 && mv[fz][fs][w] && mt[fz][fs][w] == tg(fz, fva) &&
          mvm[fz][fs][w] == fvm && mas[fz][fs][w] == fas) fw = w;
    for (int w = 0; w < 4; w++) if (fw < 0 && !mv[fz][fs][w]) fw = w;
    if (fw < 0) fw = victim(mpl[fz][fs]);
    if (lk)
      for (int z = 0; z < 2; z++)
        if (hh[z]) mpl[z][sidx(z, lva)] = touch(mpl[z][sidx(z, lva)], hw[z]);
    if (inv)
      for (int z = 0; z < 2; z++)
        for (int s = 0; s < 16; s++)
          for (int w = 0; w < 4; w++)
            case (ik)
              2'd0: mv[z][s][w] = 1'b0;
              2'd1: if (mvm[z][s][w] == ivm) mv[z][s][w] = 1'b0;
              2'd2: if (mvm[z][s][w] == ivm && mas[z][s][w] == ias) mv[z][s][w] = 1'b0;
              default: ;
            endcase
    if (fl) begin
      mv[fz][fs][fw] = 1'b1;
      mt[fz][fs][fw] = tg(fz, fva);
      mvm[fz][fs][fw] = fvm;
      mas[fz][fs][fw] = fas;
      mpf[fz][fs][fw] = flg ? {9'h0, fpa[39:21]} : fpa[39:12];
      mpe[fz][fs][fw] = fpe;
      mpl[fz][fs] = touch(mpl[fz][fs], fw);
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "rs_valid", 40'(rs_valid), 40'(lk));
    if (lk) begin
      chk(req, "rs_hit", 40'(rs_hit), 40'(e_hit));
      chk(req, "rs_large", 40'(rs_large), 40'(e_large));
      chk(req, "rs_pa", rs_pa, e_pa);
      chk(req, "rs_perm", 40'(rs_perm), 40'(e_perm));
    end
    lk_valid = 1'b0; fl_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic look(string req, logic [47:0] va, logic [VM-1:0] vm, logic [AS-1:0] as_);
    step(req, 1, va, vm, as_, 0, 0, '0, '0, '0, '0, '0, 0, 2'd3, '0, '0);
  endtask

  task automatic fill(string req, bit lg, logic [47:0] va, logic [39:0] pa,
                      logic [VM-1:0] vm, logic [AS-1:0] as_, logic [2:0] pe);
    step(req, 0, '0, '0, '0, 1, lg, va, pa, vm, as_, pe, 0, 2'd3, '0, '0);
  endtask

  task automatic inval(string req, logic [1:0] k, logic [VM-1:0] vm, logic [AS-1:0] as_);
    step(req, 0, '0, '0, '0, 0, 0, '0, '0, '0, '0, '0, 1, k, vm, as_);
  endtask

  localparam logic [47:0] VA_A = 48'h0000_1234_5678;
  localparam logic [47:0] VA_B = 48'h0000_5555_0000;
  localparam logic [47:0] VA_C = 48'h0000_7777_1000;
  localparam logic [47:0] VA_D = 48'h0000_9999_2000;

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    lk_valid = 0; fl_valid = 0; inv_valid = 0; fl_large = 0;
    lk_va = '0; fl_va = '0; fl_pa = '0; lk_vmid = '0; lk_asid = '0;
    fl_vmid = '0; fl_asid = '0; fl_perm = '0; inv_kind = 2'd3; inv_vmid = '0; inv_asid = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, first lookup misses (R5 zero fields)
    chk("R1", "rs_valid after reset", 40'(rs_valid), 40'd0);
    chk("R1", "rs_hit after reset", 40'(rs_hit), 40'd0);
    look("R1", VA_A, 3'd1, 4'd1);
    chk("R5", "miss pa", rs_pa, 40'd0);

    // R2/R3: small hit and identifier qualification
    fill("R3", 0, VA_A, 40'h00_0abc_d000, 3'd1, 4'd1, 3'd5);
    look("R3", VA_A, 3'd1, 4'd1);
    chk("R3", "small pa", rs_pa, 40'h00_0abc_d678);
    chk("R3", "small size", 40'(rs_large), 40'd0);
    look("R2", VA_A, 3'd2, 4'd1);
    chk("R2", "other vmid misses", 40'(rs_hit), 40'd0);
    look("R2", VA_A, 3'd1, 4'd2);
    chk("R2", "other asid misses", 40'(rs_hit), 40'd0);

    // R4: large entry overlapping the small one wins
    fill("R4", 1, VA_A, 40'h12_3460_0000, 3'd1, 4'd1, 3'd3);
    look("R4", VA_A, 3'd1, 4'd1);
    chk("R4", "large pa", rs_pa, 40'h12_3474_5678);
    chk("R4", "large size", 40'(rs_large), 40'd1);
    chk("R4", "large perm", 40'(rs_perm), 40'd3);

    // R11: no-op kind keeps entries
    inval("R11", 2'd3, 3'd1, 4'd1);
    look("R11", VA_A, 3'd1, 4'd1);
    chk("R11", "still hits", 40'(rs_hit), 40'd1);

    // R9: by-VMID removes only that VM
    fill("R9", 0, VA_B, 40'h00_0111_2000, 3'd2, 4'd3, 3'd1);
    inval("R9", 2'd1, 3'd2, 4'd0);
    look("R9", VA_B, 3'd2, 4'd3);
    chk("R9", "vm2 entry gone", 40'(rs_hit), 40'd0);
    look("R9", VA_A, 3'd1, 4'd1);
    chk("R9", "vm1 entry kept", 40'(rs_hit), 40'd1);

    // R10: VMID+ASID pair
    fill("R10", 0, VA_B, 40'h00_0222_3000, 3'd1, 4'd2, 3'd2);
    inval("R10", 2'd2, 3'd1, 4'd1);
    look("R10", VA_A, 3'd1, 4'd1);
    chk("R10", "pair removed", 40'(rs_hit), 40'd0);
    look("R10", VA_B, 3'd1, 4'd2);
    chk("R10", "other asid kept", 40'(rs_hit), 40'd1);

    // R8 + R12: invalidate all together with a fill, fill survives
    step("R12", 0, '0, '0, '0, 1, 0, VA_C, 40'h00_0333_4000, 3'd0, 4'd0, 3'd6,
         1, 2'd0, '0, '0);
    look("R8", VA_B, 3'd1, 4'd2);
    chk("R8", "all flushed", 40'(rs_hit), 40'd0);
    look("R12", VA_C, 3'd0, 4'd0);
    chk("R12", "fill beside flush kept", 40'(rs_hit), 40'd1);

    // R12: lookup together with fill sees old contents, next sees new
    step("R12", 1, VA_D, 3'd0, 4'd0, 1, 0, VA_D, 40'h00_0444_5000, 3'd0, 4'd0, 3'd7,
         0, 2'd3, '0, '0);
    chk("R12", "same-cycle lookup misses", 40'(rs_hit), 40'd0);
    look("R12", VA_D, 3'd0, 4'd0);
    chk("R12", "next lookup hits", 40'(rs_hit), 40'd1);

    // R6/R7: fill order, in-place refill, tree victim
    inval("R8", 2'd0, '0, '0);
    for (int i = 0; i < 4; i++)
      fill("R6", 0, {32'h0000_1000 + 32'(i), 4'h9, 12'h0}, 40'(i + 1) << 12, 3'd0, 4'd0, 3'd1);
    fill("R6", 0, {32'h0000_1001, 4'h9, 12'h0}, 40'h00_0fff_f000, 3'd0, 4'd0, 3'd2);
    for (int i = 0; i < 4; i++)
      look("R6", {32'h0000_1000 + 32'(i), 4'h9, 12'h0}, 3'd0, 4'd0);
    chk("R6", "refilled in place", rs_pa, 40'h00_0000_4000);
    look("R7", {32'h0000_1000, 4'h9, 12'h0}, 3'd0, 4'd0);
    fill("R7", 0, {32'h0000_1004, 4'h9, 12'h0}, 40'h00_0005_0000, 3'd0, 4'd0, 3'd1);
    look("R7", {32'h0000_1002, 4'h9, 12'h0}, 3'd0, 4'd0);
    chk("R7", "way 2 evicted", 40'(rs_hit), 40'd0);
    look("R7", {32'h0000_1000, 4'h9, 12'h0}, 3'd0, 4'd0);
    chk("R7", "recent way kept", 40'(rs_hit), 40'd1);
    look("R7", {32'h0000_1001, 4'h9, 12'h0}, 3'd0, 4'd0);
    chk("R6", "refilled pa kept", rs_pa, 40'h00_0fff_f000);

    // constrained random traffic against the model (R2..R12)
    for (int n = 0; n < 3000; n++) begin
      logic [47:0] a, b;
      int r;
      a = {16'h7f00, 5'd0, 3'($urandom % 6), 3'($urandom % 2), 5'd0, 4'($urandom % 2),
           12'($urandom)};
      b = {16'h7f00, 5'd0, 3'($urandom % 6), 3'($urandom % 2), 5'd0, 4'($urandom % 2), 12'h0};
      r = $urandom % 100;
      step("R2", ($urandom % 10) < 7, a, VM'($urandom % 3), AS'($urandom % 3),
           ($urandom % 10) < 3, ($urandom % 10) < 3, b,
           {20'($urandom), 20'($urandom)} & 40'hff_ffe0_0000 | 40'(($urandom % 2) << 12),
           VM'($urandom % 3), AS'($urandom % 3), 3'($urandom),
           r < 4, 2'($urandom), VM'($urandom % 3), AS'($urandom % 3));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule